// File: doc/BRIEF.md
# Set/Clear GPIO Flag Controller

This block manages a bank of general-purpose flag pins, 48 by default, through a small register bus. Each pin is set to input or output on its own. Software never needs a read-modify-write. Output levels, and the interrupt enable mask, are changed through paired registers where a 1 bit sets or clears that pin and a 0 bit leaves it alone. A status register returns the current sense of every flag. For an output pin this is the driven level. For an input pin it is the synchronized external level.

Each pin can raise an interrupt. Its trigger can be the flag level, the rising edge only, or both edges. Input pins trigger from their external signal. Output pins trigger from software-driven changes of their own flag value, which gives software interrupts. Edge events are held in a pending register that software clears by writing ones. The enabled pending bits are ORed into one registered interrupt line.

Writes take effect on the rising clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The address codes are 0 direction, 1 output-set, 2 output-clear, 3 status, 4 mask-set, 5 mask-clear, 6 trigger-kind, 7 both-edges, 8 pending. Other addresses read as zero.

Top module: `gpio_flag_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are all zero and `irq` is low. All pins are then inputs with level triggering and all interrupts disabled.
- R2: Address 0 is the direction register, read and write. Bit n = 1 makes pin n an output, and `pin_oe` follows from the edge after the write.
- R3: A write to address 1 sets every output latch bit where the written data is 1 and leaves the other bits unchanged. Addresses 1 and 2 both read back the output latch, which drives `pin_out`.
- R4: A write to address 2 clears every output latch bit where the written data is 1 and leaves the other bits unchanged.
- R5: Address 3 reads the flag sense. For an output pin this is its latch bit. For an input pin it is `pin_in` through a two-flop synchronizer, so a change first sampled at edge k is visible after edge k+1. The `pin_in` value of an output pin is ignored.
- R6: A write to address 4 sets enable mask bits where the data is 1. A write to address 5 clears mask bits where the data is 1. Both addresses read the mask.
- R7: Address 6 selects the trigger kind per pin (0 = level, 1 = edge). Address 7 selects, for edge pins, rising only (0) or both edges (1). Both are read and write.
- R8: For a level pin, the pending bit equals the flag sense after one more register stage. Writing 1 to its pending bit has no effect while the flag is high.
- R9: For an edge pin, a rising flag edge sets the pending bit and it stays set. A falling edge sets it only when the both-edges bit is 1.
- R10: Address 8 reads the pending register. Writing 1 to a bit clears that edge pending bit, and 0 bits leave pending bits unchanged.
- R11: An output pin raises events from its own latch changes by the same trigger rules as an input pin.
- R12: `irq` is the registered OR of pending bits ANDed with the enable mask. An output-set write at edge e raises `irq` after edge e+1. An input change first sampled at edge k raises it after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata | output | NUM_PINS | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | External pin levels |
| pin_out | output | NUM_PINS | Output latch levels |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Register effects are due on the edge of the write, so the bench sets inputs at the falling edge and samples the read data and pins at the next falling edge. A `pin_in` change is checked on the status register one edge later (still old) and two edges later (new). The interrupt from an input change is checked low after edges k and k+1 and high after edge k+2. For a software-set output pin, `irq` is checked low right after the write edge and high one edge later. Where exact latency is not the point, the bench waits three edges before it samples.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_DIR   = 4'd0;
    localparam logic [ADDR_W-1:0] A_OSET  = 4'd1;
    localparam logic [ADDR_W-1:0] A_OCLR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MSET  = 4'd4;
    localparam logic [ADDR_W-1:0] A_MCLR  = 4'd5;
    localparam logic [ADDR_W-1:0] A_SENSE = 4'd6;
    localparam logic [ADDR_W-1:0] A_BOTH  = 4'd7;
    localparam logic [ADDR_W-1:0] A_PEND  = 4'd8;
endpackage

// File: rtl/gpio_flag_sync.sv
module gpio_flag_sync #(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw_in,
    output logic [NUM_PINS-1:0] sync_out
);
    typedef struct packed {
        logic [NUM_PINS-1:0] stage1;
        logic [NUM_PINS-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = raw_in;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.stage2;
endmodule

// File: rtl/gpio_flag_regs.sv
module gpio_flag_regs
    import gpio_flag_pkg::*;
#(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] latch,
    output logic [NUM_PINS-1:0] mask,
    output logic [NUM_PINS-1:0] edge_sel,
    output logic [NUM_PINS-1:0] both_sel
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] mask;
        logic [NUM_PINS-1:0] edge_sel;
        logic [NUM_PINS-1:0] both_sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (addr)
                A_DIR:   cfg_d.dir      = wdata;
                A_OSET:  cfg_d.latch    = cfg_q.latch | wdata;
                A_OCLR:  cfg_d.latch    = cfg_q.latch & ~wdata;
                A_MSET:  cfg_d.mask     = cfg_q.mask | wdata;
                A_MCLR:  cfg_d.mask     = cfg_q.mask & ~wdata;
                A_SENSE: cfg_d.edge_sel = wdata;
                A_BOTH:  cfg_d.both_sel = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dir      = cfg_q.dir;
    assign latch    = cfg_q.latch;
    assign mask     = cfg_q.mask;
    assign edge_sel = cfg_q.edge_sel;
    assign both_sel = cfg_q.both_sel;
endmodule

// File: rtl/gpio_flag_event.sv
module gpio_flag_event #(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] flag,
    input  logic [NUM_PINS-1:0] edge_sel,
    input  logic [NUM_PINS-1:0] both_sel,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] pend,
    output logic                irq
);
    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] pend;
        logic                irq;
    } evt_t;

    evt_t evt_d, evt_q;
    logic [NUM_PINS-1:0] pend_nxt;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic rise, fall, hit, held;
        assign rise = flag[i] & ~evt_q.prev[i];
        assign fall = ~flag[i] & evt_q.prev[i];
        assign hit  = rise | (both_sel[i] & fall);
        assign held = evt_q.pend[i] & ~clr[i];
        // Edge pins latch until cleared; a new event beats a clear in the same cycle.
        assign pend_nxt[i] = edge_sel[i] ? (held | hit) : flag[i];
    end

    always_comb begin
        evt_d      = evt_q;
        evt_d.prev = flag;
        evt_d.pend = pend_nxt;
        evt_d.irq  = |(pend_nxt & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign pend = evt_q.pend;
    assign irq  = evt_q.irq;
endmodule

// File: rtl/gpio_flag_ctrl.sv
module gpio_flag_ctrl
    import gpio_flag_pkg::*;
#(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    logic [NUM_PINS-1:0] dir_w, latch_w, mask_w, sense_w, both_w;
    logic [NUM_PINS-1:0] sync_w, flag_w, pend_w, clr_w;

    gpio_flag_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (sync_w)
    );

    gpio_flag_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .dir      (dir_w),
        .latch    (latch_w),
        .mask     (mask_w),
        .edge_sel (sense_w),
        .both_sel (both_w)
    );

    // Output pins see their own latch, so software changes feed the same detector.
    assign flag_w = (dir_w & latch_w) | (~dir_w & sync_w);
    assign clr_w  = (bus_wr && bus_addr == A_PEND) ? bus_wdata : '0;

    gpio_flag_event #(.NUM_PINS(NUM_PINS)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag     (flag_w),
        .edge_sel (sense_w),
        .both_sel (both_w),
        .mask     (mask_w),
        .clr      (clr_w),
        .pend     (pend_w),
        .irq      (irq)
    );

    always_comb begin
        case (bus_addr)
            A_DIR:          bus_rdata = dir_w;
            A_OSET, A_OCLR: bus_rdata = latch_w;
            A_STAT:         bus_rdata = flag_w;
            A_MSET, A_MCLR: bus_rdata = mask_w;
            A_SENSE:        bus_rdata = sense_w;
            A_BOTH:         bus_rdata = both_w;
            A_PEND:         bus_rdata = pend_w;
            default:        bus_rdata = '0;
        endcase
    end

    assign pin_out = latch_w;
    assign pin_oe  = dir_w;
endmodule

// File: rtl/gpio_flag_ctrl_chk.sv
module gpio_flag_ctrl_chk
    import gpio_flag_pkg::*;
#(
    parameter int NUM_PINS = 48
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] pend_vec,
    input logic [NUM_PINS-1:0] mask_vec,
    input logic [NUM_PINS-1:0] sense_vec
);
    a_r2_dir_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_DIR) |=> $stable(pin_oe));

    a_r3_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OSET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    a_r4_clear_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OCLR) |=> ((pin_out & $past(bus_wdata)) == '0));

    a_r3_latch_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_OSET || bus_addr == A_OCLR)) |=> $stable(pin_out));

    a_r9_edge_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_PEND || bus_addr == A_SENSE))
        |=> ((pend_vec & $past(pend_vec & sense_vec)) == $past(pend_vec & sense_vec)));

    a_r12_irq_needs_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(pend_vec & $past(mask_vec))));
endmodule

bind gpio_flag_ctrl gpio_flag_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .pend_vec  (pend_w),
    .mask_vec  (mask_w),
    .sense_vec (sense_w)
);

// File: tb/test_gpio_flag_ctrl.sv
`timescale 1ns/1ps
module test_gpio_flag_ctrl;
    localparam int N = 48;
    localparam logic [N-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic         irq;

    int vectors = 0;
    int miss = 0;

    // Bench-side register model
    logic [N-1:0] m_dir = '0, m_out = '0, m_mask = '0, m_sense = '0, m_both = '0;

    always #2 clk = ~clk;

    gpio_flag_ctrl #(.NUM_PINS(N)) i_gpio_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [N-1:0] rnd();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[N-1:0];
    endfunction

    function automatic logic [N-1:0] bit_of(input int i);
        logic [N-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        case (a)
            4'd0: m_dir   = d;
            4'd1: m_out   = m_out | d;
            4'd2: m_out   = m_out & ~d;
            4'd4: m_mask  = m_mask | d;
            4'd5: m_mask  = m_mask & ~d;
            4'd6: m_sense = d;
            4'd7: m_both  = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check_model(input string tag);
        logic [N-1:0] v;
        rd(4'd0, v); chk({tag, " R2 dir"}, v, m_dir);
        rd(4'd1, v); chk({tag, " R3 latch@1"}, v, m_out);
        rd(4'd2, v); chk({tag, " R4 latch@2"}, v, m_out);
        rd(4'd4, v); chk({tag, " R6 mask@4"}, v, m_mask);
        rd(4'd5, v); chk({tag, " R6 mask@5"}, v, m_mask);
        rd(4'd6, v); chk({tag, " R7 kind"}, v, m_sense);
        rd(4'd7, v); chk({tag, " R7 both"}, v, m_both);
        chk({tag, " R2 pin_oe"}, pin_oe, m_dir);
        chk({tag, " R3 pin_out"}, pin_out, m_out);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'h5eed_0042));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        for (int a = 0; a < 9; a++) begin
            rd(a[3:0], v);
            chk("R1 reset read", v, '0);
        end
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        chk("R1 irq", irq, 0);

        // R2 R3 R4 R6 R7: random register traffic against the model
        for (int it = 0; it < 40; it++) begin
            int sel;
            sel = $urandom_range(0, 6);
            case (sel)
                0: wr(4'd0, rnd());
                1: wr(4'd1, rnd());
                2: wr(4'd2, rnd());
                3: wr(4'd4, rnd());
                4: wr(4'd5, rnd());
                5: wr(4'd6, rnd());
                default: wr(4'd7, rnd());
            endcase
            check_model("rand");
        end
        // Directed corners: all-ones and all-zeros set/clear
        wr(4'd1, ALL); check_model("set all");
        wr(4'd2, '0);  check_model("clear none");
        wr(4'd2, ALL); check_model("clear all");
        wr(4'd1, '0);  check_model("set none");

        // Back to a quiet state
        wr(4'd0, '0); wr(4'd5, ALL); wr(4'd6, '0); wr(4'd7, '0);
        tick(3);
        wr(4'd8, ALL);

        // R5: status readback mixes latch and synchronized input
        for (int it = 0; it < 8; it++) begin
            logic [N-1:0] d, o, p;
            d = rnd(); o = rnd(); p = rnd();
            wr(4'd0, d); wr(4'd1, o); wr(4'd2, ~o);
            pin_in = p;
            tick(3);
            rd(4'd3, v);
            chk("R5 status mix", v, (d & o) | (~d & p));
        end
        wr(4'd0, '0); wr(4'd2, ALL);
        pin_in = '0;
        tick(3);
        wr(4'd8, ALL);

        // R5: synchronizer latency, visible after second edge
        pin_in[3] = 1'b1;
        tick(1); rd(4'd3, v); chk("R5 sync still old", v[3], 0);
        tick(1); rd(4'd3, v); chk("R5 sync now new", v[3], 1);
        pin_in[3] = 1'b0;
        tick(3);

        // R8: level trigger on pin 0
        wr(4'd4, bit_of(0));
        pin_in[0] = 1'b1;
        tick(3);
        chk("R8 level irq", irq, 1);
        rd(4'd8, v); chk("R8 level pend", v[0], 1);
        wr(4'd8, bit_of(0));
        rd(4'd8, v); chk("R8 clear ignored while high", v[0], 1);
        pin_in[0] = 1'b0;
        tick(3);
        rd(4'd8, v); chk("R8 pend follows low", v[0], 0);
        chk("R8 irq low", irq, 0);
        wr(4'd5, bit_of(0));

        // R9 R12: rising edge on input pin 1 with exact latency
        wr(4'd6, bit_of(1));
        wr(4'd4, bit_of(1));
        pin_in[1] = 1'b1;
        tick(1); chk("R12 irq after k", irq, 0);
        tick(1); chk("R12 irq after k+1", irq, 0);
        tick(1); chk("R12 irq after k+2", irq, 1);
        pin_in[1] = 1'b0;
        tick(3);
        rd(4'd8, v); chk("R9 edge pend sticky", v[1], 1);
        wr(4'd8, '0);
        rd(4'd8, v); chk("R10 zero write keeps", v[1], 1);
        wr(4'd8, bit_of(1));
        rd(4'd8, v); chk("R10 one write clears", v[1], 0);
        tick(1); chk("R12 irq drops", irq, 0);

        // R9: falling edge ignored when rising-only
        pin_in[1] = 1'b1; tick(3);
        wr(4'd8, bit_of(1));
        pin_in[1] = 1'b0; tick(3);
        rd(4'd8, v); chk("R9 fall ignored", v[1], 0);

        // R9: both edges
        wr(4'd7, bit_of(1));
        pin_in[1] = 1'b1; tick(3);
        rd(4'd8, v); chk("R9 both rise", v[1], 1);
        wr(4'd8, bit_of(1));
        rd(4'd8, v); chk("R10 cleared before fall", v[1], 0);
        pin_in[1] = 1'b0; tick(3);
        rd(4'd8, v); chk("R9 both fall", v[1], 1);
        chk("R12 irq enabled pend", irq, 1);

        // R12: mask clear removes irq with pending still set
        wr(4'd5, bit_of(1));
        tick(1);
        chk("R12 masked irq", irq, 0);
        rd(4'd8, v); chk("R12 pend kept under mask", v[1], 1);
        wr(4'd8, ALL);
        wr(4'd7, '0);

        // R11 R12: software interrupt from output pin 5
        pin_in[5] = 1'b0;
        wr(4'd0, bit_of(5));
        wr(4'd6, bit_of(5));
        wr(4'd4, bit_of(5));
        wr(4'd1, bit_of(5));
        chk("R12 irq not yet after write edge", irq, 0);
        tick(1);
        chk("R11 software irq", irq, 1);
        rd(4'd3, v); chk("R5 output pin reads latch", v[5], 1);
        pin_in[5] = 1'b1;
        wr(4'd8, bit_of(5));
        wr(4'd2, bit_of(5));
        tick(3);
        rd(4'd8, v); chk("R11 falling output ignored", v[5], 0);
        rd(4'd3, v); chk("R5 pin_in of output ignored", v[5], 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule